// File: doc/BRIEF.md
# Incremental Line Rasterizer

This block turns a line segment into a stream of pixel coordinates. It emits one coordinate per clock until the segment is complete. A client presents the two endpoints and pulses `start`. The engine then produces one pixel per cycle, starting at the first endpoint and ending at the second. `pix_valid` marks each pixel, `busy` covers the whole operation, and `done` pulses once when the line has finished.

The engine covers lines that rise to the right at no more than 45 degrees. For these lines the first endpoint is strictly left of and strictly below the second, and the vertical span is no larger than the horizontal span. The rising condition is relaxed so that horizontal lines are also accepted. Each cycle the engine advances x by one. A signed running error term, updated with an add, a subtract and a sign test, decides whether y also advances. No slope is computed, and there is no multiplier or divider.

The sequencing is done by a three-state controller. In `S_IDLE` the engine waits for `start`, and the idle-to-draw transition is called *launch*. In `S_DRAW` it emits one pixel per cycle. It stays there through the *step* transition while x has not reached its end. It leaves by the *finish* transition on the pixel at the end x. `S_FINISH` lasts one cycle and raises `done`. The *retire* transition then returns the engine to `S_IDLE`.

Top module: `line_raster`

## Requirements
- R1: While `rst` is high at a clock edge, the engine returns to `S_IDLE` after that edge, with `pix_valid`, `busy` and `done` all low. This also applies in the middle of a line.
- R2: When `start` is high at an edge while the engine is idle, the endpoints are captured at that edge. From the next cycle, `busy` is high and the first pixel (`x0`,`y0`) is presented with `pix_valid` high.
- R3: `pix_valid` stays high for exactly `x1-x0+1` consecutive cycles. `pix_x` rises by one on each of those cycles, and its last value is `x1`.
- R4: The y coordinate follows a running error value. The error starts at `(x1-x0)>>1`. After each pixel, `y1-y0` is subtracted from it. If the result is negative, y advances by one for the next pixel and `x1-x0` is added back to the error in the same step.
- R5: On consecutive valid pixels, y either stays the same or rises by one. The last pixel has y equal to `y1`.
- R6: `done` is high for exactly one cycle, the cycle after the last pixel. `pix_valid` is low in that cycle. `busy` falls in the cycle after that.
- R7: `start` has no effect while `busy` is high. The line in progress continues with its original endpoints.
- R8: A horizontal line (`y1 = y0`) keeps y constant at `y0` for every pixel.
- R9: A 45-degree line (`y1-y0 = x1-x0`) advances y on every pixel after the first.
- R10: Once `busy` has fallen, the engine accepts a new `start` at the next edge and draws the new line correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a line; only acted on while idle |
| x0 | input | CW | First endpoint, x |
| y0 | input | CW | First endpoint, y |
| x1 | input | CW | Second endpoint, x |
| y1 | input | CW | Second endpoint, y |
| pix_x | output | CW | Current pixel x |
| pix_y | output | CW | Current pixel y |
| pix_valid | output | 1 | Pixel coordinate is valid this cycle |
| busy | output | 1 | A line is in progress |
| done | output | 1 | One-cycle pulse after the last pixel |

## Verification
The bench sweeps every span from 1 to 12 pixels, with every rise from zero to the full span. This covers the horizontal and 45-degree extremes, where a wrong sign test or a missing add-back either freezes y or lets it drift past `y1`. The shortest line (span 1, initial error 0) targets an off-by-one in the stop compare, which would emit one pixel too many or too few. Full-range 255-pixel lines target an error register that is too narrow, which would wrap and make y jump. Further runs cover a `start` pulse in the middle of a line, which must not restart it, and a reset in the middle of a line, which must clear `pix_valid` at once.

// File: rtl/line_raster_pkg.sv
package line_raster_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_DRAW   = 2'd1,
        S_FINISH = 2'd2
    } lr_state_t;

endpackage

// File: rtl/line_raster_ctrl.sv
module line_raster_ctrl
    import line_raster_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic at_end,
    output logic load,
    output logic step,
    output logic pix_valid,
    output logic busy,
    output logic done
);

    lr_state_t state_q;
    lr_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: launch, step, finish, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start)  state_d = S_DRAW;
            S_DRAW:   if (at_end) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load      = 1'b0;
        step      = 1'b0;
        pix_valid = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                load = start;
            end
            S_DRAW: begin
                step      = ~at_end;
                pix_valid = 1'b1;
                busy      = 1'b1;
            end
            S_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: begin
                load = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/line_raster_dp.sv
module line_raster_dp #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          load,
    input  logic          step,
    input  logic [CW-1:0] x0,
    input  logic [CW-1:0] y0,
    input  logic [CW-1:0] x1,
    input  logic [CW-1:0] y1,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] pix_y,
    output logic          at_end
);

    localparam int EW = CW + 1;

    logic [CW-1:0]        x_q, y_q, xend_q, run_q, rise_q;
    logic signed [EW-1:0] err_q;
    logic [CW-1:0]        run_in, rise_in;
    logic signed [EW-1:0] err_sub, err_next;
    logic                 y_adv;

    assign run_in  = x1 - x0;
    assign rise_in = y1 - y0;

    always_comb begin
        err_sub  = err_q - $signed({1'b0, rise_q});
        y_adv    = err_sub[EW-1];
        err_next = y_adv ? (err_sub + $signed({1'b0, run_q})) : err_sub;
    end

    always_ff @(posedge clk) begin
        if (load) begin
            x_q    <= x0;
            y_q    <= y0;
            xend_q <= x1;
            run_q  <= run_in;
            rise_q <= rise_in;
            err_q  <= $signed({2'b00, run_in[CW-1:1]});
        end else if (step) begin
            x_q   <= x_q + 1'b1;
            y_q   <= y_adv ? (y_q + 1'b1) : y_q;
            err_q <= err_next;
        end
    end

    assign pix_x  = x_q;
    assign pix_y  = y_q;
    assign at_end = (x_q == xend_q);

endmodule

// File: rtl/line_raster.sv
module line_raster #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] x0,
    input  logic [CW-1:0] y0,
    input  logic [CW-1:0] x1,
    input  logic [CW-1:0] y1,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] pix_y,
    output logic          pix_valid,
    output logic          busy,
    output logic          done
);

    logic load, step, at_end;

    line_raster_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .at_end    (at_end),
        .load      (load),
        .step      (step),
        .pix_valid (pix_valid),
        .busy      (busy),
        .done      (done)
    );

    line_raster_dp #(.CW(CW)) u_dp (
        .clk    (clk),
        .load   (load),
        .step   (step),
        .x0     (x0),
        .y0     (y0),
        .x1     (x1),
        .y1     (y1),
        .pix_x  (pix_x),
        .pix_y  (pix_y),
        .at_end (at_end)
    );

endmodule

// File: rtl/line_raster_chk.sv
module line_raster_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [CW-1:0] x0,
    input logic [CW-1:0] y0,
    input logic [CW-1:0] x1,
    input logic [CW-1:0] pix_x,
    input logic [CW-1:0] pix_y,
    input logic          pix_valid,
    input logic          busy,
    input logic          done
);

    logic [CW-1:0] xend_seen;

    always_ff @(posedge clk) begin
        if (start && !busy) xend_seen <= x1;
    end

    AST_LAUNCH_FIRST: assert property (@(posedge clk) disable iff (rst)
        ($past(start) && !$past(busy) && !$past(rst)) |-> (pix_valid && busy && pix_x == $past(x0) && pix_y == $past(y0))); // R2

    AST_X_STEP: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && $past(pix_valid)) |-> (pix_x == $past(pix_x) + 1'b1)); // R3

    AST_Y_STEP: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && $past(pix_valid)) |-> (pix_y == $past(pix_y) || pix_y == $past(pix_y) + 1'b1)); // R5

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(pix_valid) && !pix_valid && $past(pix_x) == xend_seen)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)); // R6

    AST_VALID_BUSY: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> busy); // R2

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (!pix_valid && !busy && !done)); // R1

endmodule

bind line_raster line_raster_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .x0        (x0),
    .y0        (y0),
    .x1        (x1),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .pix_valid (pix_valid),
    .busy      (busy),
    .done      (done)
);

// File: tb/line_raster_test.sv
`timescale 1ns/1ps
module line_raster_test;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] x0 = '0, y0 = '0, x1 = '0, y1 = '0;
    logic [CW-1:0] pix_x, pix_y;
    logic          pix_valid, busy, done;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    line_raster #(.CW(CW)) uut (
        .clk(clk), .rst(rst), .start(start),
        .x0(x0), .y0(y0), .x1(x1), .y1(y1),
        .pix_x(pix_x), .pix_y(pix_y),
        .pix_valid(pix_valid), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // draw a line and compare against the error-term model;
    // inject >= 0 pulses start with other endpoints after that pixel (R7)
    task automatic run_line(input int ax, input int ay, input int bx, input int by, input int inject);
        int run, rise, err, ey;
        run  = bx - ax;
        rise = by - ay;
        err  = run / 2;
        ey   = ay;
        @(negedge clk);
        x0 = ax[CW-1:0]; y0 = ay[CW-1:0]; x1 = bx[CW-1:0]; y1 = by[CW-1:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n <= run; n++) begin
            chk(pix_valid == 1'b1, "R3 valid", int'(pix_valid), 1);
            chk(busy == 1'b1, "R2 busy", int'(busy), 1);
            chk(int'(pix_x) == ax + n, "R3 x", int'(pix_x), ax + n);
            chk(int'(pix_y) == ey, (rise == 0) ? "R8 y" : ((rise == run) ? "R9 y" : "R4 y"), int'(pix_y), ey);
            if (n == run) chk(int'(pix_y) == by, "R5 last y", int'(pix_y), by);
            chk(done == 1'b0, "R6 no early done", int'(done), 0);
            err = err - rise;
            if (err < 0) begin
                ey++;
                err = err + run;
            end
            if (n == inject) begin
                x0 = 8'd3; y0 = 8'd200; x1 = 8'd9; y1 = 8'd201;
                start = 1'b1;
            end
            @(negedge clk);
            if (n == inject) begin
                start = 1'b0;
                x0 = ax[CW-1:0]; y0 = ay[CW-1:0];
            end
        end
        chk(pix_valid == 1'b0, "R6 valid off", int'(pix_valid), 0);
        chk(done == 1'b1, "R6 done", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R6 done once", int'(done), 0);
        chk(busy == 1'b0, "R6 busy off", int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pix_valid == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 reset idle",
            int'({pix_valid, busy, done}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 idle after reset", int'(busy), 0);

        // exhaustive small sweep, back-to-back lines (R10)
        for (int run = 1; run <= 12; run++) begin
            for (int rise = 0; rise <= run; rise++) begin
                int ax, ay;
                ax = (run * 13 + rise * 5) % 200;
                ay = (rise * 17 + run * 3) % 200;
                run_line(ax, ay, ax + run, ay + rise, -1);
            end
        end

        // full range lines, error term near its width limit
        run_line(0, 0, 255, 255, -1);
        run_line(0, 0, 255, 0, -1);
        run_line(0, 0, 255, 1, -1);
        run_line(0, 0, 255, 254, -1);
        run_line(0, 100, 255, 227, -1);

        // start while busy is ignored (R7)
        run_line(20, 30, 40, 37, 4);
        run_line(50, 50, 60, 60, 0);
        run_line(10, 10, 15, 12, 5);

        // reset in the middle of a line (R1)
        @(negedge clk);
        x0 = 8'd0; y0 = 8'd0; x1 = 8'd100; y1 = 8'd30;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(pix_valid == 1'b0, "R1 mid reset valid", int'(pix_valid), 0);
        chk(busy == 1'b0, "R1 mid reset busy", int'(busy), 0);
        chk(done == 1'b0, "R1 mid reset done", int'(done), 0);
        rst = 1'b0;
        run_line(7, 9, 19, 14, -1);   // R10 after reset

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule